// File: doc/BRIEF.md
# Colour LCD Controller Register Interface

This block is the software-visible register file of a simple colour LCD controller. A processor reaches it through a 4 KB, word-aligned, APB-style port (select, enable, write strobe, 12-bit byte address, 32-bit data). It stores the four panel timing words, the frame base addresses for the upper and lower panel halves, a control word, an interrupt mask and an interrupt status. It also carries eight read-only identification bytes at the top of the map.

Besides serving reads and writes, the block decodes the stored words for the rest of the controller. The active width and height come from packed timing fields. The enable state, pixel depth and ordering flags come from the control word. An interrupt line is the OR of the masked status bits. Status bits are set by event pulses from the display engine and cleared by software with write-one-to-clear. A parameter picks one of two controller variants. The variants swap the offsets of the control and mask registers and report different identification bytes.

Top module: `lcdc_regfile`

## Requirements
- R1: After synchronous reset every stored register is zero. The decoded width is therefore 16, the height 1, the display inactive and the interrupt output low.
- R2: A write to word index 0 sets the width to ((value & 0xFC) + 4) * 4. A write to index 1 sets the height to (value & 0x3FF) + 1. All four timing words (indices 0 to 3) read back the full written value.
- R3: Index 4 holds the upper-panel base and index 5 the lower-panel base. Both read back and appear on their outputs.
- R4: With ENHANCED=0 the control word sits at index 6 and the mask at index 7; with ENHANCED=1 these two offsets are swapped.
- R5: Control bit 0 is enable and bit 11 is power, and the display is active only when both are set. Bits [3:1] give the pixel-depth code, bit 8 BGR ordering, bit 9 big-endian bytes and bit 10 big-endian pixels within a byte.
- R6: An event pulse on event bit n sets status bit n. Index 8 reads raw status and index 9 reads status ANDed with the mask.
- R7: A write to index 10 clears every status bit that is 1 in the written value. An event arriving in the same cycle wins over the clear.
- R8: The interrupt output is high exactly when some status bit and its mask bit are both set.
- R9: Word indices 0x3F8 to 0x3FF (byte offsets 0xFE0 to 0xFFC) read one identification byte each in bits [7:0]: 10 11 04 00 0D F0 05 B1 (hex) for the base variant and 11 11 24 00 0D F0 05 B1 for the enhanced one.
- R10: Indices 11 and 12 read the current upper and lower frame addresses supplied on input ports.
- R11: Accesses to undefined indices read zero, writes to them change nothing, and the error output is high during that access phase. Writes to the read-only indices (8, 9, 11, 12, identification) are ignored without error.
- R12: A transfer takes effect only in its access phase (select and enable both high). A setup phase alone writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Port select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address, bits [1:0] ignored |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while selected for a read |
| pslverr | output | 1 | High during an access phase to an undefined offset |
| evt_in | input | NIRQ | Status-setting event pulses |
| cur_upper | input | 32 | Current upper-panel frame address |
| cur_lower | input | 32 | Current lower-panel frame address |
| irq | output | 1 | OR of masked status bits |
| disp_active | output | 1 | Enable and power both set |
| panel_cols | output | 11 | Active width in pixels |
| panel_rows | output | 11 | Active height in lines |
| bpp_mode | output | 3 | Pixel-depth code |
| bgr_order | output | 1 | BGR component ordering |
| be_byte | output | 1 | Big-endian byte order |
| be_pixel | output | 1 | Big-endian pixel order within a byte |
| upper_base | output | 32 | Upper-panel frame base |
| lower_base | output | 32 | Lower-panel frame base |
| timing2 | output | 32 | Timing word 2 |
| timing3 | output | 32 | Timing word 3 |

## Verification
The hardest situation to reach is a status clear that lands in the same cycle as a new event on the same bit. The bench gets there by asserting the event pulses inside the access phase of a write to the clear index. Random transfers do the same with random event patterns. Both variants sit on one shared bus, so every write to index 6 or 7 lands in the control word of one instance and the mask of the other. This exposes the offset swap and its effect on the enable and interrupt outputs with every such transfer.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 12;
    localparam int IDX_W    = ADDR_W - 2;
    localparam int NUM_TIM  = 4;
    localparam int COL_W    = 11;
    localparam int ROW_W    = 11;
    localparam int ID_BYTES = 8;
    localparam logic [IDX_W-1:0] IX_ID_BASE = IDX_W'(1024 - ID_BYTES);

    typedef enum logic [3:0] {
        SEL_NONE, SEL_TIM, SEL_UBASE, SEL_LBASE, SEL_CTRL, SEL_MASK,
        SEL_RAW, SEL_MSTAT, SEL_CLR, SEL_CUP, SEL_CLO, SEL_ID
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e   sel;
        logic [1:0] sub;
        logic [2:0] id_k;
    } dec_t;

    typedef struct packed {
        logic       pwr;
        logic       be_pix;
        logic       be_byte;
        logic       bgr;
        logic [2:0] bpp;
        logic       en;
    } ctrl_view_t;

    // Word index to register selection; the variant swaps control and mask.
    function automatic dec_t decode_index(logic [IDX_W-1:0] ix, logic enh);
        dec_t d;
        d.sel  = SEL_NONE;
        d.sub  = ix[1:0];
        d.id_k = ix[2:0];
        if (ix >= IX_ID_BASE) begin
            d.sel = SEL_ID;
        end else begin
            case (ix)
                10'd0, 10'd1, 10'd2, 10'd3: d.sel = SEL_TIM;
                10'd4:  d.sel = SEL_UBASE;
                10'd5:  d.sel = SEL_LBASE;
                10'd6:  d.sel = enh ? SEL_MASK : SEL_CTRL;
                10'd7:  d.sel = enh ? SEL_CTRL : SEL_MASK;
                10'd8:  d.sel = SEL_RAW;
                10'd9:  d.sel = SEL_MSTAT;
                10'd10: d.sel = SEL_CLR;
                10'd11: d.sel = SEL_CUP;
                10'd12: d.sel = SEL_CLO;
                default: d.sel = SEL_NONE;
            endcase
        end
        return d;
    endfunction

    function automatic logic [7:0] id_byte(logic enh, logic [2:0] k);
        case (k)
            3'd0:    return enh ? 8'h11 : 8'h10;
            3'd1:    return 8'h11;
            3'd2:    return enh ? 8'h24 : 8'h04;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

    function automatic ctrl_view_t unpack_ctrl(logic [11:0] c);
        ctrl_view_t v;
        v.en      = c[0];
        v.bpp     = c[3:1];
        v.bgr     = c[8];
        v.be_byte = c[9];
        v.be_pix  = c[10];
        v.pwr     = c[11];
        return v;
    endfunction

    function automatic logic [COL_W-1:0] width_of(logic [DATA_W-1:0] t);
        logic [COL_W-1:0] w;
        w = COL_W'({t[7:2], 2'b00}) + COL_W'(4);
        return w << 2;
    endfunction

    function automatic logic [ROW_W-1:0] height_of(logic [DATA_W-1:0] t);
        return ROW_W'(t[9:0]) + ROW_W'(1);
    endfunction

endpackage

// File: rtl/lcdc_geom.sv
module lcdc_geom
    import lcdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] tim [NUM_TIM],
    output logic [COL_W-1:0]  cols,
    output logic [ROW_W-1:0]  rows
);

    for (genvar i = 0; i < NUM_TIM; i++) begin : g_tim
        always_ff @(posedge clk) begin
            if (rst)                      tim[i] <= '0;
            else if (we && sel == 2'(i))  tim[i] <= wdata;
        end
    end

    assign cols = width_of(tim[0]);
    assign rows = height_of(tim[1]);

    p_width_r2: assert property (@(posedge clk) disable iff (rst)
        (we && sel == 2'd0) |=> cols == COL_W'((($past(wdata) & 32'hFC) + 32'd4) * 32'd4));

    p_height_r2: assert property (@(posedge clk) disable iff (rst)
        (we && sel == 2'd1) |=> rows == ROW_W'(($past(wdata) & 32'h3FF) + 32'd1));

endmodule

// File: rtl/lcdc_irq.sv
module lcdc_irq
    import lcdc_pkg::*;
#(
    parameter int NIRQ = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mask_we,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NIRQ-1:0]   evt,
    output logic [NIRQ-1:0]   stat,
    output logic [NIRQ-1:0]   mask,
    output logic              irq
);

    logic [NIRQ-1:0] wbits;
    assign wbits = wdata[NIRQ-1:0];
    wire unused_hi = ^wdata[DATA_W-1:NIRQ];

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
            mask <= '0;
        end else begin
            stat <= (clr_we ? (stat & ~wbits) : stat) | evt;
            if (mask_we) mask <= wbits;
        end
    end

    assign irq = |(stat & mask);

    p_w1c_r7: assert property (@(posedge clk) disable iff (rst)
        (clr_we && (evt & wbits) == '0) |=> (stat & $past(wbits)) == '0);

    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> (stat & $past(evt)) == $past(evt));

    p_irq_on_r8: assert property (@(posedge clk) disable iff (rst)
        ((|(evt & mask)) && !mask_we) |=> irq);

    p_irq_off_r8: assert property (@(posedge clk) disable iff (rst)
        (mask == '0 && !mask_we) |=> !irq);

endmodule

// File: rtl/lcdc_id_rom.sv
module lcdc_id_rom
    import lcdc_pkg::*;
#(
    parameter bit ENHANCED = 1'b0
) (
    input  logic [2:0] k,
    output logic [7:0] id_b
);

    logic [7:0] rom [ID_BYTES];

    for (genvar i = 0; i < ID_BYTES; i++) begin : g_rom
        assign rom[i] = id_byte(ENHANCED, 3'(i));
    end

    assign id_b = rom[k];

endmodule

// File: rtl/lcdc_regfile.sv
module lcdc_regfile
    import lcdc_pkg::*;
#(
    parameter bit ENHANCED = 1'b0,
    parameter int NIRQ     = 5,
    parameter int CTRL_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [11:0]       paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pslverr,
    input  logic [NIRQ-1:0]   evt_in,
    input  logic [31:0]       cur_upper,
    input  logic [31:0]       cur_lower,
    output logic              irq,
    output logic              disp_active,
    output logic [10:0]       panel_cols,
    output logic [10:0]       panel_rows,
    output logic [2:0]        bpp_mode,
    output logic              bgr_order,
    output logic              be_byte,
    output logic              be_pixel,
    output logic [31:0]       upper_base,
    output logic [31:0]       lower_base,
    output logic [31:0]       timing2,
    output logic [31:0]       timing3
);

    wire unused_lsb = ^paddr[1:0];

    logic access, wr;
    dec_t dec;
    assign access = psel & penable;
    assign wr     = access & pwrite;
    assign dec    = decode_index(paddr[ADDR_W-1:2], ENHANCED);

    logic tim_we, ctrl_we, mask_we, clr_we;
    assign tim_we  = wr && dec.sel == SEL_TIM;
    assign ctrl_we = wr && dec.sel == SEL_CTRL;
    assign mask_we = wr && dec.sel == SEL_MASK;
    assign clr_we  = wr && dec.sel == SEL_CLR;

    // Timing words and geometry decode
    logic [DATA_W-1:0] tim [NUM_TIM];
    lcdc_geom u_geom (
        .clk   (clk),
        .rst   (rst),
        .we    (tim_we),
        .sel   (dec.sub),
        .wdata (pwdata),
        .tim   (tim),
        .cols  (panel_cols),
        .rows  (panel_rows)
    );
    assign timing2 = tim[2];
    assign timing3 = tim[3];

    // Frame bases and control word
    logic [DATA_W-1:0] ubase_q, lbase_q;
    logic [CTRL_W-1:0] ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ubase_q <= '0;
            lbase_q <= '0;
            ctrl_q  <= '0;
        end else if (wr) begin
            if (dec.sel == SEL_UBASE) ubase_q <= pwdata;
            if (dec.sel == SEL_LBASE) lbase_q <= pwdata;
            if (ctrl_we)              ctrl_q  <= pwdata[CTRL_W-1:0];
        end
    end

    ctrl_view_t cv;
    assign cv          = unpack_ctrl(ctrl_q[11:0]);
    assign disp_active = cv.en & cv.pwr;
    assign bpp_mode    = cv.bpp;
    assign bgr_order   = cv.bgr;
    assign be_byte     = cv.be_byte;
    assign be_pixel    = cv.be_pix;
    assign upper_base  = ubase_q;
    assign lower_base  = lbase_q;

    // Interrupt status and mask
    logic [NIRQ-1:0] stat, mask;
    lcdc_irq #(.NIRQ(NIRQ)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .mask_we (mask_we),
        .clr_we  (clr_we),
        .wdata   (pwdata),
        .evt     (evt_in),
        .stat    (stat),
        .mask    (mask),
        .irq     (irq)
    );

    // Identification bytes
    logic [7:0] id_b;
    lcdc_id_rom #(.ENHANCED(ENHANCED)) u_id (
        .k    (dec.id_k),
        .id_b (id_b)
    );

    // Read mux
    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            case (dec.sel)
                SEL_TIM:   prdata = tim[dec.sub];
                SEL_UBASE: prdata = ubase_q;
                SEL_LBASE: prdata = lbase_q;
                SEL_CTRL:  prdata = DATA_W'(ctrl_q);
                SEL_MASK:  prdata = DATA_W'(mask);
                SEL_RAW:   prdata = DATA_W'(stat);
                SEL_MSTAT: prdata = DATA_W'(stat & mask);
                SEL_CUP:   prdata = cur_upper;
                SEL_CLO:   prdata = cur_lower;
                SEL_ID:    prdata = DATA_W'(id_b);
                default:   prdata = '0;
            endcase
        end
    end

    assign pslverr = access && dec.sel == SEL_NONE;

    p_err_phase_r11: assert property (@(posedge clk) disable iff (rst)
        pslverr |-> (psel && penable));

    p_active_src_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(disp_active) |-> $past(ctrl_we));

    p_setup_only_r12: assert property (@(posedge clk) disable iff (rst)
        (psel && !penable) |=> ($stable(upper_base) && $stable(lower_base) && $stable(timing2)));

endmodule

// File: tb/lcdc_regfile_test.sv
module lcdc_regfile_test;
    localparam int NIRQ = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        psel = 0, penable = 0, pwrite = 0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [NIRQ-1:0] evt_in = '0;
    logic [31:0] cur_upper = 32'h1234_5670, cur_lower = 32'h89AB_CDE8;

    logic [31:0] rdat [2];
    logic        err [2], irq_o [2], act [2], bgr [2], beb [2], bep [2];
    logic [10:0] cols [2], rows [2];
    logic [2:0]  bpp [2];
    logic [31:0] ub_o [2], lb_o [2], t2_o [2], t3_o [2];

    lcdc_regfile #(.ENHANCED(1'b0), .NIRQ(NIRQ)) uut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(rdat[0]), .pslverr(err[0]),
        .evt_in(evt_in), .cur_upper(cur_upper), .cur_lower(cur_lower),
        .irq(irq_o[0]), .disp_active(act[0]), .panel_cols(cols[0]), .panel_rows(rows[0]),
        .bpp_mode(bpp[0]), .bgr_order(bgr[0]), .be_byte(beb[0]), .be_pixel(bep[0]),
        .upper_base(ub_o[0]), .lower_base(lb_o[0]), .timing2(t2_o[0]), .timing3(t3_o[0]));

    lcdc_regfile #(.ENHANCED(1'b1), .NIRQ(NIRQ)) uut_enh (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(rdat[1]), .pslverr(err[1]),
        .evt_in(evt_in), .cur_upper(cur_upper), .cur_lower(cur_lower),
        .irq(irq_o[1]), .disp_active(act[1]), .panel_cols(cols[1]), .panel_rows(rows[1]),
        .bpp_mode(bpp[1]), .bgr_order(bgr[1]), .be_byte(beb[1]), .be_pixel(bep[1]),
        .upper_base(ub_o[1]), .lower_base(lb_o[1]), .timing2(t2_o[1]), .timing3(t3_o[1]));

    // Reference model
    logic [31:0] m_tim [4];
    logic [31:0] m_ub, m_lb;
    logic [15:0] m_ctrl [2];
    logic [4:0]  m_mask [2];
    logic [4:0]  m_stat;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    function automatic int ctrl_ix(int v); return (v == 1) ? 7 : 6; endfunction
    function automatic int mask_ix(int v); return (v == 1) ? 6 : 7; endfunction
    function automatic bit is_def(int ix); return (ix <= 12) || (ix >= 'h3F8); endfunction

    function automatic logic [7:0] id_exp(int v, int k);
        logic [7:0] b [8];
        b = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        if (v == 1) begin b[0] = 8'h11; b[2] = 8'h24; end
        return b[k];
    endfunction

    function automatic logic [31:0] exp_read(int v, int ix);
        if (ix >= 'h3F8)        return {24'h0, id_exp(v, ix - 'h3F8)};
        if (ix < 4)             return m_tim[ix];
        if (ix == 4)            return m_ub;
        if (ix == 5)            return m_lb;
        if (ix == ctrl_ix(v))   return {16'h0, m_ctrl[v]};
        if (ix == mask_ix(v))   return {27'h0, m_mask[v]};
        if (ix == 8)            return {27'h0, m_stat};
        if (ix == 9)            return {27'h0, m_stat & m_mask[v]};
        if (ix == 11)           return cur_upper;
        if (ix == 12)           return cur_lower;
        return 32'h0;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] a, input logic [31:0] e);
        n_chk++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, a, e);
        end
    endtask

    task automatic model_write(input int ix, input logic [31:0] d, input logic [4:0] ev);
        if (ix < 4) m_tim[ix] = d;
        if (ix == 4) m_ub = d;
        if (ix == 5) m_lb = d;
        for (int v = 0; v < 2; v++) begin
            if (ix == ctrl_ix(v)) m_ctrl[v] = d[15:0];
            if (ix == mask_ix(v)) m_mask[v] = d[4:0];
        end
        if (ix == 10) m_stat = m_stat & ~d[4:0];
        m_stat = m_stat | ev;
    endtask

    task automatic check_outputs(input string req);
        for (int v = 0; v < 2; v++) begin
            chk(req, $sformatf("v%0d irq", v), {31'h0, irq_o[v]}, {31'h0, |(m_stat & m_mask[v])});
            chk(req, $sformatf("v%0d active", v), {31'h0, act[v]}, {31'h0, m_ctrl[v][0] & m_ctrl[v][11]});
            chk(req, $sformatf("v%0d cols", v), {21'h0, cols[v]}, ((m_tim[0] & 32'hFC) + 32'd4) * 32'd4);
            chk(req, $sformatf("v%0d rows", v), {21'h0, rows[v]}, (m_tim[1] & 32'h3FF) + 32'd1);
            chk(req, $sformatf("v%0d flags", v), {26'h0, bpp[v], bgr[v], beb[v], bep[v]},
                {26'h0, m_ctrl[v][3:1], m_ctrl[v][8], m_ctrl[v][9], m_ctrl[v][10]});
            chk(req, $sformatf("v%0d ubase", v), ub_o[v], m_ub);
            chk(req, $sformatf("v%0d lbase", v), lb_o[v], m_lb);
            chk(req, $sformatf("v%0d t2", v), t2_o[v], m_tim[2]);
            chk(req, $sformatf("v%0d t3", v), t3_o[v], m_tim[3]);
        end
    endtask

    task automatic bus_write(input string req, input int ix, input logic [31:0] d, input logic [4:0] ev);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = 1; paddr = {ix[9:0], 2'b00}; pwdata = d;
        @(negedge clk);
        penable = 1; evt_in = ev;
        #1;
        for (int v = 0; v < 2; v++)
            chk(req, $sformatf("v%0d wr err ix %0h", v, ix), {31'h0, err[v]}, {31'h0, !is_def(ix)});
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0; evt_in = '0;
        model_write(ix, d, ev);
    endtask

    task automatic bus_read(input string req, input int ix, input logic [4:0] ev);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = 0; paddr = {ix[9:0], 2'b00};
        @(negedge clk);
        penable = 1; evt_in = ev;
        #1;
        for (int v = 0; v < 2; v++) begin
            chk(req, $sformatf("v%0d rd ix %0h", v, ix), rdat[v], exp_read(v, ix));
            chk(req, $sformatf("v%0d rd err ix %0h", v, ix), {31'h0, err[v]}, {31'h0, !is_def(ix)});
        end
        @(negedge clk);
        psel = 0; penable = 0; evt_in = '0;
        m_stat = m_stat | ev;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1CDC));
        for (int i = 0; i < 4; i++) m_tim[i] = '0;
        m_ub = '0; m_lb = '0; m_stat = '0;
        for (int v = 0; v < 2; v++) begin m_ctrl[v] = '0; m_mask[v] = '0; end

        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;

        // R1: reset state
        check_outputs("R1");
        for (int ix = 0; ix <= 12; ix++) bus_read("R1", ix, '0);

        // R2: geometry extremes and full readback
        bus_write("R2", 0, 32'hFFFF_FFFF, '0);
        chk("R2", "width max", {21'h0, cols[0]}, 32'd1024);
        bus_write("R2", 0, 32'h0000_0103, '0);
        chk("R2", "width min", {21'h0, cols[1]}, 32'd16);
        bus_write("R2", 1, 32'h0000_03FF, '0);
        chk("R2", "height max", {21'h0, rows[0]}, 32'd1024);
        bus_write("R2", 1, 32'hFFFF_FC00, '0);
        chk("R2", "height min", {21'h0, rows[1]}, 32'd1);
        bus_write("R2", 2, 32'hA5A5_0F0F, '0);
        bus_write("R2", 3, 32'h0123_4567, '0);
        for (int ix = 0; ix < 4; ix++) bus_read("R2", ix, '0);

        // R3: frame bases
        bus_write("R3", 4, 32'h8000_0000, '0);
        bus_write("R3", 5, 32'h0004_B000, '0);
        bus_read("R3", 4, '0);
        bus_read("R3", 5, '0);
        check_outputs("R3");

        // R4 / R5: index 6 and 7 land in different registers per variant
        bus_write("R4", 6, 32'h0000_0801, '0);
        bus_write("R4", 7, 32'h0000_070B, '0);
        chk("R5", "base active en+pwr", {31'h0, act[0]}, 32'd1);
        chk("R5", "enh inactive no pwr", {31'h0, act[1]}, 32'd0);
        check_outputs("R5");
        bus_read("R4", 6, '0);
        bus_read("R4", 7, '0);
        bus_write("R5", 7, 32'h0000_0800, '0);
        chk("R5", "enh power only", {31'h0, act[1]}, 32'd0);
        check_outputs("R5");

        // R6 / R8: events, raw and masked status
        bus_read("R6", 8, 5'b00110);
        bus_read("R6", 8, '0);
        bus_read("R6", 9, '0);
        check_outputs("R8");
        bus_write("R8", 6, 32'h0000_001F, '0);
        bus_write("R8", 7, 32'h0000_0004, '0);
        check_outputs("R8");

        // R7: clear and simultaneous set
        bus_write("R7", 10, 32'h0000_0006, 5'b00010);
        bus_read("R7", 8, '0);
        bus_write("R7", 10, 32'hFFFF_FFFF, '0);
        bus_read("R7", 8, '0);
        check_outputs("R7");

        // R9: identification bytes
        for (int ix = 'h3F8; ix <= 'h3FF; ix++) bus_read("R9", ix, '0);

        // R10: current frame addresses
        bus_read("R10", 11, '0);
        bus_read("R10", 12, '0);
        cur_upper = 32'hDEAD_0000; cur_lower = 32'h0000_BEEF;
        bus_read("R10", 11, '0);
        bus_read("R10", 12, '0);

        // R11: undefined and read-only offsets
        bus_write("R11", 'h80, 32'hFFFF_FFFF, '0);
        bus_read("R11", 'hC0, '0);
        bus_read("R11", 13, '0);
        bus_write("R11", 11, 32'h5555_5555, '0);
        bus_write("R11", 'h3F9, 32'h0000_00FF, '0);
        bus_write("R11", 8, 32'h0000_001F, '0);
        bus_read("R11", 'h3F9, '0);
        for (int ix = 0; ix <= 12; ix++) bus_read("R11", ix, '0);
        check_outputs("R11");

        // R12: setup phase only
        @(negedge clk);
        psel = 1; penable = 0; pwrite = 1; paddr = 12'h010; pwdata = 32'hCAFE_F00D;
        @(negedge clk);
        psel = 0; pwrite = 0;
        check_outputs("R12");
        bus_read("R12", 4, '0);

        // Random traffic against the model
        for (int n = 0; n < 500; n++) begin
            int sel, ix;
            logic [4:0] ev;
            sel = $urandom_range(0, 19);
            if (sel < 14)      ix = $urandom_range(0, 12);
            else if (sel < 17) ix = $urandom_range('h3F8, 'h3FF);
            else               ix = $urandom_range(0, 1023);
            ev = ($urandom_range(0, 3) == 0) ? 5'($urandom) : 5'h0;
            if ($urandom_range(0, 1) == 1) bus_write("R7", ix, $urandom, ev);
            else                           bus_read("R6", ix, ev);
            if (n % 25 == 0) check_outputs("R8");
        end
        check_outputs("R2");

        done = 1;
        summary();
        $finish;
    end

endmodule